// File: doc/BRIEF.md
# Dithered Third-Order Cascaded Sigma-Delta Modulator

This block produces the per-reference-cycle modulus selection for a fractional-N frequency divider. Three first-order accumulators are chained; each hands its registered residue to the next and contributes only its carry bit. A cancellation network combines the carries into a small signed correction. The correction is added to the integer part of the division ratio. Over time, the average divide ratio then equals the integer part plus the fractional word divided by 256.

Periodic carry patterns cause spurious tones. To break them up, an on-chip 8-bit pseudorandom generator supplies one bit per cycle. That bit overwrites the lowest bit of the words fed to the second and third accumulators. No extra adder is needed, and the first stage, which alone sets the mean, is left untouched. An enable input freezes the whole modulator. A synchronous reset returns it to a known starting point, so its output sequence is fully repeatable.

Top module: `mash_dither_mod`

## Requirements
- R1: While `rst` is high at a rising clock edge, all three accumulators and all carry delay registers clear, the pseudorandom register loads the seed 0xE1, and after that edge `yOut` reads 0 and `divOut` reads 0.
- R2: The pseudorandom register shifts toward its most significant bit once per enabled cycle. The new bit 0 is the XOR of bits 7, 5, 4 and 3 (polynomial x^8+x^6+x^5+x^4+1). The dither bit used in a cycle is bit 7. The register never holds zero outside reset.
- R3: On each enabled cycle, the first accumulator adds `fracIn` modulo 256. Its carry is bit 8 of that 9-bit sum.
- R4: On each enabled cycle, the second accumulator adds its predecessor's registered residue with bit 0 replaced by the dither bit. The third accumulator does the same with the second's residue. With `fracIn` held at zero, the dither alone makes `yOut` nonzero in some cycles.
- R5: With k1, k2, k3 the carries of the three stages in a cycle and primes marking the values one and two enabled cycles earlier, the registered output is k1'' + k2' − k2'' + k3 − 2·k3' + k3''.
- R6: `yOut` is a 4-bit two's-complement value that always lies in −3 to +4.
- R7: `divOut` is `nInt` plus the sign-extended new `yOut`, updated on the same edge as `yOut`.
- R8: In a cycle with `en` low, no state changes and both outputs hold, whatever `fracIn` and `nInt` do. When `en` returns, the output sequence continues exactly as if the idle cycles had not occurred.
- R9: Over any 1024 consecutive enabled cycles starting at least two cycles after reset with a constant `fracIn` of x, the sum of `yOut` is within ±3 of 4·x.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the modulator this cycle |
| fracIn | input | 8 | Fractional part of the ratio, in units of 1/256 |
| nInt | input | 8 | Integer part of the division ratio |
| yOut | output | 4 | Signed modulator correction |
| divOut | output | 9 | Instantaneous divide ratio |

## Verification
The assertions take for granted that `nInt` is at least 3, so the unsigned ratio never wraps below zero. They also assume `rst` is high on the first clock edge, so the seed is loaded before any check of the pseudorandom register is armed. The stimulus keeps `nInt` between 3 and 251 and holds reset through the first cycles of every scenario. It changes `fracIn` and `nInt` freely while `en` is low, to show they are ignored there. Every output value is compared against a cycle model built from the stage, dither and cancellation rules above. The long-run mean is checked separately from that model.

// File: rtl/mash_pkg.sv
package mash_pkg;

  // Correction range -3..+4 needs four two's-complement bits.
  localparam int MOD_OUT_W = 4;

  // Number of cascaded first-order stages (fixed third order).
  localparam int MOD_STAGES = 3;

  // Strobes from control to datapath.
  typedef struct packed {
    logic step;   // advance all state this cycle
    logic clear;  // synchronous clear / seed load
  } mashStrobe_t;

endpackage

// File: rtl/mash_ctrl.sv
module mash_ctrl
  import mash_pkg::*;
(
  input  logic        rst,
  input  logic        en,
  output mashStrobe_t strobe
);

  // Reset wins over enable; both are sampled on the same edge.
  always_comb begin
    strobe.clear = rst;
    strobe.step  = en & ~rst;
  end

endmodule

// File: rtl/pn_gen.sv
module pn_gen
  import mash_pkg::*;
#(
  parameter int              PN_W    = 8,
  parameter logic [PN_W-1:0] PN_TAPS = 8'hB8,
  parameter logic [PN_W-1:0] PN_SEED = 8'hE1
) (
  input  logic        clk,
  input  mashStrobe_t strobe,
  output logic        ditherBit
);

  logic [PN_W-1:0] pnState;
  logic            feedback;

  assign feedback  = ^(pnState & PN_TAPS);
  assign ditherBit = pnState[PN_W-1];

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      pnState <= PN_SEED;
    end else if (strobe.step) begin
      pnState <= {pnState[PN_W-2:0], feedback};
    end
  end

  // R2
  pn_nonzero_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    pnState != '0);

  // R8
  pn_hold_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.step |=> $stable(pnState));

endmodule

// File: rtl/mash_stage.sv
module mash_stage
  import mash_pkg::*;
#(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  mashStrobe_t      strobe,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] residue,
  output logic             carry
);

  logic [ACC_W:0] sumWide;

  assign sumWide = {1'b0, residue} + {1'b0, addend};
  assign carry   = sumWide[ACC_W];

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      residue <= '0;
    end else if (strobe.step) begin
      residue <= sumWide[ACC_W-1:0];
    end
  end

  // R8
  stage_hold_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.step |=> $stable(residue));

endmodule

// File: rtl/mash_path.sv
module mash_path
  import mash_pkg::*;
#(
  parameter int ACC_W = 8,
  parameter int INT_W = 8
) (
  input  logic                        clk,
  input  mashStrobe_t                 strobe,
  input  logic                        ditherBit,
  input  logic [ACC_W-1:0]            fracIn,
  input  logic [INT_W-1:0]            nInt,
  output logic signed [MOD_OUT_W-1:0] yOut,
  output logic [INT_W:0]              divOut
);

  localparam int OW = MOD_OUT_W;
  localparam int DW = INT_W + 1;
  localparam int NS = MOD_STAGES;

  logic [ACC_W-1:0] residue [NS];
  logic [NS-1:0]    carry;

  // Cascade: stage 0 sees the fractional word, later stages see the
  // registered residue of their predecessor with bit 0 replaced by dither.
  for (genvar g = 0; g < NS; g++) begin : gStage
    logic [ACC_W-1:0] addend;
    if (g == 0) begin : gHead
      assign addend = fracIn;
    end else begin : gTail
      assign addend = {residue[g-1][ACC_W-1:1], ditherBit};
    end
    mash_stage #(.ACC_W(ACC_W)) uStage (
      .clk     (clk),
      .strobe  (strobe),
      .addend  (addend),
      .residue (residue[g]),
      .carry   (carry[g])
    );
  end

  // Two-deep carry history per stage: [0] one cycle back, [1] two back.
  logic [1:0] cDly [NS];

  always_ff @(posedge clk) begin
    for (int s = 0; s < NS; s++) begin
      if (strobe.clear) begin
        cDly[s] <= '0;
      end else if (strobe.step) begin
        cDly[s] <= {cDly[s][0], carry[s]};
      end
    end
  end

  // Noise cancellation, aligned for one pipeline register per stage.
  logic signed [OW-1:0] yNext;
  logic [DW-1:0]        divNext;

  always_comb begin
    yNext = OW'(cDly[0][1])
          + OW'(cDly[1][0]) - OW'(cDly[1][1])
          + OW'(carry[2]) - (OW'(cDly[2][0]) << 1) + OW'(cDly[2][1]);
    divNext = DW'(nInt) + {{(DW-OW){yNext[OW-1]}}, yNext};
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      yOut   <= '0;
      divOut <= '0;
    end else if (strobe.step) begin
      yOut   <= yNext;
      divOut <= divNext;
    end
  end

  // R6
  y_range_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    (yOut >= -3) && (yOut <= 4));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    strobe.clear |=> (yOut == '0) && (divOut == '0));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.step |=> $stable(yOut) && $stable(divOut));

endmodule

// File: rtl/mash_dither_mod.sv
module mash_dither_mod
  import mash_pkg::*;
#(
  parameter int              ACC_W   = 8,
  parameter int              INT_W   = 8,
  parameter int              PN_W    = 8,
  parameter logic [PN_W-1:0] PN_TAPS = 8'hB8,
  parameter logic [PN_W-1:0] PN_SEED = 8'hE1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic [ACC_W-1:0]            fracIn,
  input  logic [INT_W-1:0]            nInt,
  output logic signed [MOD_OUT_W-1:0] yOut,
  output logic [INT_W:0]              divOut
);

  mashStrobe_t strobe;
  logic        ditherBit;

  mash_ctrl uCtrl (
    .rst    (rst),
    .en     (en),
    .strobe (strobe)
  );

  pn_gen #(
    .PN_W    (PN_W),
    .PN_TAPS (PN_TAPS),
    .PN_SEED (PN_SEED)
  ) uPn (
    .clk       (clk),
    .strobe    (strobe),
    .ditherBit (ditherBit)
  );

  mash_path #(
    .ACC_W (ACC_W),
    .INT_W (INT_W)
  ) uPath (
    .clk       (clk),
    .strobe    (strobe),
    .ditherBit (ditherBit),
    .fracIn    (fracIn),
    .nInt      (nInt),
    .yOut      (yOut),
    .divOut    (divOut)
  );

  // R7
  div_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !rst) |=> (int'(divOut) == int'($past(nInt)) + int'(yOut)));

endmodule

// File: tb/mash_dither_mod_test.sv
module mash_dither_mod_test;

  logic              clk    = 1'b0;
  logic              rst    = 1'b1;
  logic              en     = 1'b0;
  logic [7:0]        fracIn = 8'd0;
  logic [7:0]        nInt   = 8'd78;
  logic signed [3:0] yOut;
  logic [8:0]        divOut;

  int total = 0;
  int bad   = 0;

  // Cycle model state, built from the requirements.
  int         mA1, mA2, mA3;
  int         c1a, c1b, c2a, c2b, c3a, c3b;
  logic [7:0] mPn;
  int         expY, expDiv;

  mash_dither_mod uut (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .fracIn (fracIn),
    .nInt   (nInt),
    .yOut   (yOut),
    .divOut (divOut)
  );

  always #10 clk = ~clk;

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mA1 = 0; mA2 = 0; mA3 = 0;
    c1a = 0; c1b = 0; c2a = 0; c2b = 0; c3a = 0; c3b = 0;
    mPn = 8'hE1;
    expY = 0; expDiv = 0;
  endtask

  task automatic modelStep(int x, int n);
    int d, s1, s2, s3, k1, k2, k3;
    d  = int'(mPn[7]);
    s1 = mA1 + x;                 k1 = (s1 >= 256) ? 1 : 0;
    s2 = mA2 + ((mA1 & 254) | d); k2 = (s2 >= 256) ? 1 : 0;
    s3 = mA3 + ((mA2 & 254) | d); k3 = (s3 >= 256) ? 1 : 0;
    expY   = c1b + c2a - c2b + k3 - 2 * c3a + c3b;
    expDiv = n + expY;
    mA1 = s1 % 256; mA2 = s2 % 256; mA3 = s3 % 256;
    c1b = c1a; c1a = k1;
    c2b = c2a; c2a = k2;
    c3b = c3a; c3a = k3;
    mPn = {mPn[6:0], mPn[7] ^ mPn[5] ^ mPn[4] ^ mPn[3]};
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic tick(logic e, logic [7:0] x, logic [7:0] n);
    en = e; fracIn = x; nInt = n;
    if (rst) modelReset();
    else if (e) modelStep(int'(x), int'(n));
    @(negedge clk);
  endtask

  task automatic applyReset();
    rst = 1'b1;
    tick(1'b1, 8'h41, 8'd78);
    tick(1'b1, 8'h41, 8'd78);
    rst = 1'b0;
    // R1
    check("R1", "yOut after reset", int'(yOut), 0);
    check("R1", "divOut after reset", int'(divOut), 0);
  endtask

  task automatic runCompare(logic [7:0] x, logic [7:0] n, int cycles, string req);
    for (int i = 0; i < cycles; i++) begin
      tick(1'b1, x, n);
      check(req, "yOut", int'(yOut), expY);
      // R7
      check("R7", "divOut", int'(divOut), expDiv);
      // R6
      check("R6", "yOut in -3..4", int'((yOut >= -3) && (yOut <= 4)), 1);
    end
  endtask

  task automatic testPatterns();
    applyReset();
    runCompare(8'h41, 8'd78, 400, "R5");
    runCompare(8'hFF, 8'd251, 300, "R3");
    runCompare(8'h80, 8'd3, 300, "R3");
    runCompare(8'h01, 8'd120, 300, "R5");
  endtask

  task automatic testDither();
    int nz = 0;
    applyReset();
    for (int i = 0; i < 600; i++) begin
      tick(1'b1, 8'h00, 8'd78);
      check("R2", "yOut with zero input", int'(yOut), expY);
      if (yOut != 0) nz++;
    end
    // R4: dither alone must produce activity
    check("R4", "nonzero count is positive", int'(nz > 0), 1);
  endtask

  task automatic testEnableGap();
    int heldY, heldDiv;
    applyReset();
    runCompare(8'h41, 8'd78, 50, "R5");
    heldY = int'(yOut); heldDiv = int'(divOut);
    for (int i = 0; i < 12; i++) begin
      tick(1'b0, 8'(i * 17 + 3), 8'(100 + i));
      // R8
      check("R8", "yOut held while idle", int'(yOut), heldY);
      check("R8", "divOut held while idle", int'(divOut), heldDiv);
    end
    runCompare(8'h41, 8'd78, 60, "R8");
  endtask

  task automatic testMidReset();
    applyReset();
    runCompare(8'hC3, 8'd90, 137, "R5");
    applyReset();
    runCompare(8'hC3, 8'd90, 200, "R2");
  endtask

  task automatic testMean(logic [7:0] x);
    int sum = 0;
    int diff;
    applyReset();
    runCompare(x, 8'd78, 8, "R5");
    for (int i = 0; i < 1024; i++) begin
      tick(1'b1, x, 8'd78);
      sum += int'(yOut);
    end
    diff = sum - 4 * int'(x);
    total++;
    // R9
    if (diff > 3 || diff < -3) begin
      bad++;
      $display("FAIL R9 mean sum actual=%0d expected=%0d (+-3)", sum, 4 * int'(x));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog all-reqs actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    modelReset();
    @(negedge clk);
    testPatterns();
    testDither();
    testEnableGap();
    testMidReset();
    testMean(8'h41);
    testMean(8'h01);
    testMean(8'hFF);
    testMean(8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule